// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a non-blocking time-slot interchange for 1024 byte-wide channels. The channels are 32 streams of 32 channels each, carried byte-interleaved on one 8-bit parallel bus. A free-running slot counter, which a frame pulse can realign, names the slot being served each clock cycle. Every incoming byte is stored in a two-bank data memory at the address of its slot. The bank being written changes at each frame start, and reads always come from the other bank. A byte therefore reaches its output exactly one frame after it arrived, whichever source and destination slots are involved.

For each output slot, a 16-bit word in the connection memory names the source slot (bits 9:0) and holds three per-slot controls. Bit 10 disables the output driver. Bit 11 is message enable: the slot then sends bits 7:0 of the word in place of switched data. Bit 12 is a mode level. Bits 15:13 are spare. Software writes and reads these words through a small processor port. Source and controls are written together in one write.

Top module: `tsi_switch`

## Requirements
- R1: The served slot advances by one each clock cycle and wraps from 1023 to 0. The outputs for a served slot appear one cycle later, and `out_slot_o` gives that slot's number.
- R2: A cycle with `frame_i` high serves slot 0, and counting continues from there. `out_slot_o` reads 0 in the following cycle.
- R3: A slot number is channel*32 + stream (channel in bits 9:5, stream in bits 4:0). To connect a source to a destination, the source slot number is written into the connection entry addressed by the destination slot. For example, entry 0x141 (channel 10, stream 1) holding 0x082 (channel 4, stream 2) routes that source to that destination.
- R4: In frame F, an output slot whose entry has bits 10 and 11 clear sends the byte that arrived at its source slot in frame F-1. This holds whether the source slot comes before or after the destination slot.
- R5: While reset is held, every output and `rdata_o` is zero. After reset, every connection entry reads as zero.
- R6: When bit 10 of a slot's entry is 1, `out_drv_o` is 0 and `out_data_o` is 0 for that slot only. Neighbouring slots are unaffected.
- R7: Bits 11 and 12 of a slot's entry appear on `msg_en_o` and `mode_o` in that slot's output cycle.
- R8: When bit 11 is 1 and bit 10 is 0, `out_data_o` is bits 7:0 of the entry.
- R9: A port cycle with `cpu_cs_i`=1 and `cpu_wr_i`=1 stores `cpu_wdata_i` at `cpu_addr_i`. A port cycle with `cpu_wr_i`=0 returns the whole stored 16-bit word on `rdata_o` in the next cycle. Bits 15:13 are returned but have no effect on switching.
- R10: A write made in the cycle its slot is being served takes effect the next time that slot is served. A write made in an earlier cycle of the same frame is used in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one byte slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Marks slot 0 and realigns the counter |
| in_data_i | input | 8 | Byte arriving in the current slot |
| cpu_cs_i | input | 1 | Processor port select |
| cpu_wr_i | input | 1 | 1 write, 0 read |
| cpu_addr_i | input | 10 | Connection entry address (output slot) |
| cpu_wdata_i | input | 16 | Word to store |
| rdata_o | output | 16 | Word read back, one cycle after the read |
| out_slot_o | output | 10 | Slot whose results are on the outputs |
| out_data_o | output | 8 | Switched or message byte |
| out_drv_o | output | 1 | Output driver enable (0 = disabled) |
| msg_en_o | output | 1 | Message enable bit of the slot |
| mode_o | output | 1 | Mode select bit of the slot |

## Verification
Outputs for a slot served in cycle N are registered and can be read at the falling edge after edge N. A port read is likewise visible one falling edge later. Switched data depends on the byte sent into the source slot one full frame earlier. The bench drives a pattern it can recompute from the frame index and slot number, and keeps its own copy of the connection entries. In each cycle it works out the expected result for the slot being served and compares it at the next falling edge, together with `out_slot_o`. It updates its copy of the entries only after that calculation, so a write made during its own slot is expected to take effect one frame later.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int SLOT_W   = 10;
  localparam int STREAM_W = 5;
  localparam int DATA_W   = 8;
  localparam int CM_W     = 16;
  localparam int SLOTS    = 1 << SLOT_W;
  localparam int SPARE_W  = CM_W - SLOT_W - 3;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic               mode;
    logic               msg;
    logic               odis;
    logic [SLOT_W-1:0]  src;
  } cm_word_t;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [SLOT_W-STREAM_W-1:0] chan,
                                                input logic [STREAM_W-1:0] strm);
    return {chan, strm};
  endfunction

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return s + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] pick_byte(input cm_word_t w,
                                                  input logic [DATA_W-1:0] stored);
    if (w.odis) return '0;
    if (w.msg)  return w.src[DATA_W-1:0];
    return stored;
  endfunction
endpackage

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wbank_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              bank_q;
  logic              frame_start;

  assign slot_o      = frame_i ? '0 : slot_q;
  assign frame_start = (slot_o == '0);
  assign wbank_o     = frame_start ? ~bank_q : bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      bank_q <= 1'b0;
    end else begin
      slot_q <= next_slot(slot_o);
      bank_q <= wbank_o;
    end
  end
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              wbank_i,
  input  logic [SLOT_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SLOT_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 * SLOTS;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    mem[{wbank_i, waddr_i}] <= wdata_i;
  end

  assign rdata_o = mem[{~wbank_i, raddr_i}];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] addr_i,
  input  logic [CM_W-1:0]   wdata_i,
  output logic [CM_W-1:0]   rdata_o,
  input  logic [SLOT_W-1:0] serve_i,
  output cm_word_t          serve_word_o
);
  logic [CM_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0] vld;
  logic             wr_hit;
  logic             rd_hit;

  assign wr_hit = cs_i && wr_i;
  assign rd_hit = cs_i && !wr_i;

  always_ff @(posedge clk) begin
    if (wr_hit) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_hit) vld[addr_i] <= 1'b1;
      if (rd_hit) rdata_o <= vld[addr_i] ? mem[addr_i] : '0;
    end
  end

  assign serve_word_o = vld[serve_i] ? cm_word_t'(mem[serve_i]) : cm_word_t'('0);
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              cpu_cs_i,
  input  logic              cpu_wr_i,
  input  logic [SLOT_W-1:0] cpu_addr_i,
  input  logic [CM_W-1:0]   cpu_wdata_i,
  output logic [CM_W-1:0]   rdata_o,
  output logic [SLOT_W-1:0] out_slot_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_drv_o,
  output logic              msg_en_o,
  output logic              mode_o
);
  logic [SLOT_W-1:0] cur_slot;
  logic              wbank;
  logic [DATA_W-1:0] stored_byte;
  logic [DATA_W-1:0] cm_low;
  cm_word_t          serve_word;

  tsi_slot_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .slot_o(cur_slot), .wbank_o(wbank)
  );

  tsi_data_mem u_dmem (
    .clk(clk), .wbank_i(wbank), .waddr_i(cur_slot), .wdata_i(in_data_i),
    .raddr_i(serve_word.src), .rdata_o(stored_byte)
  );

  tsi_conn_mem u_cmem (
    .clk(clk), .rst_n(rst_n), .cs_i(cpu_cs_i), .wr_i(cpu_wr_i),
    .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i), .rdata_o(rdata_o),
    .serve_i(cur_slot), .serve_word_o(serve_word)
  );

  assign cm_low = serve_word.src[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_slot_o <= '0;
      out_data_o <= '0;
      out_drv_o  <= 1'b0;
      msg_en_o   <= 1'b0;
      mode_o     <= 1'b0;
    end else begin
      out_slot_o <= cur_slot;
      out_data_o <= pick_byte(serve_word, stored_byte);
      out_drv_o  <= ~serve_word.odis;
      msg_en_o   <= serve_word.msg;
      mode_o     <= serve_word.mode;
    end
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_i,
  input logic [SLOT_W-1:0] cur_slot,
  input logic              wbank,
  input logic [DATA_W-1:0] cm_low,
  input logic [SLOT_W-1:0] out_slot_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_drv_o,
  input logic              msg_en_o
);
  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_i || cur_slot == SLOT_W'($past(cur_slot) + 1'b1)));

  // R2
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (out_slot_o == '0));

  // R4
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_slot == '1) |=> (wbank != $past(wbank)));

  // R6
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_drv_o |-> (out_data_o == '0));

  // R8
  msg_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!msg_en_o || !out_drv_o || out_data_o == $past(cm_low)));
endmodule

bind tsi_switch tsi_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .cur_slot(cur_slot),
  .wbank(wbank), .cm_low(cm_low), .out_slot_o(out_slot_o),
  .out_data_o(out_data_o), .out_drv_o(out_drv_o), .msg_en_o(msg_en_o)
);

// File: tb/tb_tsi_switch.sv
module tb_tsi_switch;
  localparam int CLK_NS = 10;
  localparam int NSLOT  = 1024;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        frame_i = 0;
  logic [7:0]  in_data_i = 0;
  logic        cpu_cs_i = 0;
  logic        cpu_wr_i = 0;
  logic [9:0]  cpu_addr_i = 0;
  logic [15:0] cpu_wdata_i = 0;
  logic [15:0] rdata_o;
  logic [9:0]  out_slot_o;
  logic [7:0]  out_data_o;
  logic        out_drv_o, msg_en_o, mode_o;

  tsi_switch dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] shadow [NSLOT];

  logic        exp_vld = 0, exp_dchk = 0;
  logic [9:0]  exp_slot;
  logic [7:0]  exp_data;
  logic        exp_drv, exp_msg, exp_mode;
  string       exp_tag;

  function automatic logic [7:0] pat(input int f, input int s);
    return 8'((s & 255) ^ (s >> 3)) + 8'(f * 29 + 3);
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  task automatic check_pending();
    if (exp_vld) begin
      check(out_slot_o == exp_slot && out_drv_o == exp_drv && msg_en_o == exp_msg &&
            mode_o == exp_mode && (!exp_dchk || out_data_o == exp_data), exp_tag,
            $sformatf("slot act %h exp %h drv %b/%b msg %b/%b mode %b/%b data %h/%h",
                      out_slot_o, exp_slot, out_drv_o, exp_drv, msg_en_o, exp_msg,
                      mode_o, exp_mode, out_data_o, exp_data));
      exp_vld = 0;
    end
  endtask

  // one frame; optional processor write issued during slot wr_at
  task automatic run_frame(input int f, input bit dchk, input int wr_at,
                           input logic [9:0] wa, input logic [15:0] wv);
    for (int s = 0; s < NSLOT; s++) begin
      @(negedge clk);
      check_pending();
      frame_i   = (s == 0);
      in_data_i = pat(f, s);
      exp_vld   = 1;
      exp_slot  = 10'(s);
      exp_drv   = !shadow[s][10];
      exp_msg   = shadow[s][11];
      exp_mode  = shadow[s][12];
      exp_dchk  = dchk || (shadow[s][11] || shadow[s][10]);
      if (shadow[s][10])      begin exp_data = 8'h00;             exp_tag = "R6"; end
      else if (shadow[s][11]) begin exp_data = shadow[s][7:0];    exp_tag = "R8"; end
      else                    begin exp_data = pat(f - 1, int'(shadow[s][9:0])); exp_tag = "R4"; end
      if (s == wr_at) begin
        cpu_cs_i = 1; cpu_wr_i = 1; cpu_addr_i = wa; cpu_wdata_i = wv;
        shadow[wa] = wv;   // applied after this slot's expectation (R10)
      end else begin
        cpu_cs_i = 0; cpu_wr_i = 0;
      end
    end
  endtask

  task automatic drain();
    @(negedge clk);
    check_pending();
    frame_i = 0; cpu_cs_i = 0;
  endtask

  task automatic cpu_write(input logic [9:0] a, input logic [15:0] v);
    @(negedge clk);
    cpu_cs_i = 1; cpu_wr_i = 1; cpu_addr_i = a; cpu_wdata_i = v;
    shadow[a] = v;
    @(negedge clk);
    cpu_cs_i = 0; cpu_wr_i = 0;
  endtask

  task automatic cpu_read(input logic [9:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    cpu_cs_i = 1; cpu_wr_i = 0; cpu_addr_i = a;
    @(negedge clk);
    cpu_cs_i = 0;
    check(rdata_o == e, tag, $sformatf("read %h act %h exp %h", a, rdata_o, e));
  endtask

  task automatic t_reset();
    for (int i = 0; i < NSLOT; i++) shadow[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(out_data_o == 0 && out_drv_o == 0 && msg_en_o == 0 && mode_o == 0 &&
          out_slot_o == 0 && rdata_o == 0, "R5",
          $sformatf("reset outputs act %h/%b/%b/%b exp 0", out_data_o, out_drv_o, msg_en_o, mode_o));
    rst_n = 1;
    cpu_read(10'h141, 16'h0000, "R5");
    cpu_read(10'h3FF, 16'h0000, "R5");
  endtask

  task automatic t_program();
    // R3: channel 10 stream 1 fed from channel 4 stream 2
    cpu_write(10'((10 << 5) | 1), 16'((4 << 5) | 2));
    cpu_write(10'h005, 16'h0400 | 16'h0010);   // R6 disabled slot
    cpu_write(10'h006, 16'h0800 | 16'h00A5);   // R8 message
    cpu_write(10'h007, 16'h1000 | 16'h0003);   // R7 mode level
    cpu_write(10'h008, 16'h1800 | 16'h005A);   // R7 both bits
    cpu_write(10'h010, 16'h03F0);              // R4 source after destination
    cpu_write(10'h020, 16'hE001);              // R9 spare bits set
    cpu_read(10'h141, 16'h0082, "R3");
    cpu_read(10'h020, 16'hE001, "R9");
    cpu_read(10'h006, 16'h08A5, "R9");
  endtask

  task automatic t_routing();
    run_frame(0, 0, -1, '0, '0);
    run_frame(1, 1, -1, '0, '0);
  endtask

  task automatic t_write_timing();
    // R10: written while slot 0x300 is served: old entry used now, new next frame
    run_frame(2, 1, 16'h300, 10'h300, 16'h0005);
    // R10: written ahead of slot 0x200 in the same frame: used at once
    run_frame(3, 1, 16'h1FF, 10'h200, 16'h0007);
    drain();
  endtask

  task automatic t_resync();
    repeat (37) @(negedge clk);
    frame_i = 1;
    @(negedge clk);
    frame_i = 0;
    check(out_slot_o == 0, "R2", $sformatf("slot after pulse act %h exp 0", out_slot_o));
    @(negedge clk);
    check(out_slot_o == 1, "R1", $sformatf("slot step act %h exp 1", out_slot_o));
    repeat (NSLOT - 2) @(negedge clk);
    check(out_slot_o == 10'h3FF, "R1", $sformatf("slot before wrap act %h exp 3ff", out_slot_o));
    @(negedge clk);
    check(out_slot_o == 0, "R1", $sformatf("slot wrap act %h exp 0", out_slot_o));
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_program();
    t_routing();
    t_write_timing();
    t_resync();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule